// File: doc/BRIEF.md
# Peripheral Reset and Clock Sequencer

This block takes a peripheral through a controlled reset by writing to a system-control register space. That space has separate set-style and clear-style strobe registers for the clock enable and for the reset, plus read-only status bits. One start pulse runs a fixed four-step sequence:

1. Assert reset.
2. Gate the clock.
3. Release reset.
4. Ungate the clock.

Each step issues a single-cycle write of the value 1 to its strobe register. The block then polls one status bit, once per clock, until the bit shows the level that confirms the step. If the level does not appear within a parameterised poll budget, the sequence stops with an error, and a 2-bit index names the step that failed.

The bus fabric and the real clock gating lie outside the block. The write side appears as a strobe with an address and data. The two status bits arrive as synchronous inputs. The paired register offsets follow one rule: the clear-style register sits 4 bytes above its set-style partner.

Top module: `peri_reset_seq`

## Requirements
- R1: A start pulse sampled while idle makes the next cycle carry a write strobe to the reset-assert address (parameter RST_ON_OFS, default 0xA38).
- R2: The four write addresses come in this order: RST_ON_OFS, CLK_ON_OFS+4, RST_ON_OFS+4, CLK_ON_OFS (defaults 0xA38, 0x33C, 0xA3C, 0x338). There is exactly one strobe per step, and a step's strobe follows only the confirmation of the step before it.
- R3: Every write strobe lasts exactly one cycle, and the write data is 1 whenever the strobe is high.
- R4: The confirming levels are checked once per cycle, starting the cycle after each strobe:
  - step 0 needs rstStatusBit=1;
  - step 1 needs clkStatusBit=0;
  - step 2 needs rstStatusBit=0;
  - step 3 needs clkStatusBit=1.
- R5: A step whose level is not seen within POLL_LIMIT consecutive polls ends the sequence. The block then sets seqErr=1 and sets errStep to the step index (0 to 3, in issue order), and busy drops. A match on the last allowed poll still counts as success.
- R6: Confirmation of step 3 sets seqDone and drops busy. seqDone and seqErr hold until the next accepted start, which clears both and clears errStep. The two flags are never both 1, and both are 0 while busy.
- R7: A start pulse while busy is ignored. The running sequence keeps its order and its strobe count.
- R8: After reset the block is idle, with no strobe and seqDone, seqErr and errStep all 0.
- R9: While idle, after done or after an error, no write strobe is issued until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the sequence |
| clkStatusBit | input | 1 | Clock status bit (1 = running) |
| rstStatusBit | input | 1 | Reset status bit (1 = held in reset) |
| wrStrobe | output | 1 | Single-cycle write strobe |
| wrAddr | output | ADDR_W | Byte offset of the strobe register; 0 when no strobe |
| wrData | output | DATA_W | Write data, 1 during a strobe |
| busy | output | 1 | Sequence in progress |
| seqDone | output | 1 | Last sequence completed |
| seqErr | output | 1 | Last sequence timed out |
| errStep | output | 2 | Index of the step that timed out |

## Verification
Suppose the step register or the poll counter takes a wrong value. The first sign at the ports is a strobe to the wrong address, or a strobe that arrives a cycle early or late. It can also show as an error that comes one poll too early or too late, with a wrong errStep. The reference model follows every cycle, so such a fault is caught in the very cycle where the strobe or flag departs from it. The poll-budget boundary is probed at exactly POLL_LIMIT and at POLL_LIMIT+1 cycles of status latency, where an off-by-one in the counter changes success into failure.

// File: rtl/peri_reset_seq_pkg.sv
package peri_reset_seq_pkg;

  localparam int NUM_STEPS = 4;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_POLL  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic beginSeq;
    logic pollStep;
    logic nextStep;
    logic finishOk;
    logic finishErr;
  } seqCtl_t;

endpackage

// File: rtl/peri_reset_seq_ctrl.sv
module peri_reset_seq_ctrl
  import peri_reset_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    levelMatch,
  input  logic    budgetGone,
  input  logic    lastStep,
  output seqCtl_t ctl,
  output logic    wrStrobe,
  output logic    busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.beginSeq = 1'b1;
          nextState    = ST_WRITE;
        end
      end
      ST_WRITE: nextState = ST_POLL;
      ST_POLL: begin
        ctl.pollStep = 1'b1;
        if (levelMatch) begin
          if (lastStep) begin
            ctl.finishOk = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            ctl.nextStep = 1'b1;
            nextState    = ST_WRITE;
          end
        end else if (budgetGone) begin
          ctl.finishErr = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign wrStrobe = (state == ST_WRITE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/peri_reset_seq_dp.sv
module peri_reset_seq_dp
  import peri_reset_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned POLL_LIMIT = 1000000,
  parameter int unsigned CLK_ON_OFS = 'h338,
  parameter int unsigned RST_ON_OFS = 'hA38,
  parameter int unsigned PAIR_GAP   = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              clkStatusBit,
  input  logic              rstStatusBit,
  output logic              levelMatch,
  output logic              budgetGone,
  output logic              lastStep,
  output logic [ADDR_W-1:0] stepAddr,
  output logic              seqDone,
  output logic              seqErr,
  output logic [STEP_W-1:0] errStep
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  // step order: assert reset, gate clock, release reset, ungate clock
  localparam logic [NUM_STEPS-1:0] WANT_HIGH = 4'b1001;

  logic [STEP_W-1:0] stepQ;
  logic [CNT_W-1:0]  pollCnt;
  logic [ADDR_W-1:0] stepAddrTbl [NUM_STEPS];
  logic [NUM_STEPS-1:0] stepSeen;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    // even steps touch the reset pair, odd steps the clock pair
    localparam logic [ADDR_W-1:0] BASE =
      (g % 2 == 0) ? ADDR_W'(RST_ON_OFS) : ADDR_W'(CLK_ON_OFS);
    // the middle two steps use the clear-style register of the pair
    localparam logic [ADDR_W-1:0] GAP =
      (g == 1 || g == 2) ? ADDR_W'(PAIR_GAP) : '0;
    assign stepAddrTbl[g] = BASE + GAP;
    if (g % 2 == 0) begin : g_rst
      assign stepSeen[g] = (rstStatusBit == WANT_HIGH[g]);
    end else begin : g_clk
      assign stepSeen[g] = (clkStatusBit == WANT_HIGH[g]);
    end
  end

  assign levelMatch = stepSeen[stepQ];
  assign budgetGone = (pollCnt == CNT_W'(POLL_LIMIT - 1));
  assign lastStep   = (stepQ == STEP_W'(NUM_STEPS - 1));
  assign stepAddr   = stepAddrTbl[stepQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ   <= '0;
      pollCnt <= '0;
      seqDone <= 1'b0;
      seqErr  <= 1'b0;
      errStep <= '0;
    end else begin
      if (ctl.beginSeq) begin
        stepQ   <= '0;
        pollCnt <= '0;
        seqDone <= 1'b0;
        seqErr  <= 1'b0;
        errStep <= '0;
      end else if (ctl.nextStep) begin
        stepQ   <= stepQ + 1'b1;
        pollCnt <= '0;
      end else if (ctl.pollStep) begin
        pollCnt <= pollCnt + 1'b1;
      end
      if (ctl.finishOk)  seqDone <= 1'b1;
      if (ctl.finishErr) begin
        seqErr  <= 1'b1;
        errStep <= stepQ;
      end
    end
  end

endmodule

// File: rtl/peri_reset_seq.sv
module peri_reset_seq
  import peri_reset_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int unsigned POLL_LIMIT = 1000000,
  parameter int unsigned CLK_ON_OFS = 'h338,
  parameter int unsigned RST_ON_OFS = 'hA38,
  parameter int unsigned PAIR_GAP   = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              clkStatusBit,
  input  logic              rstStatusBit,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              seqDone,
  output logic              seqErr,
  output logic [1:0]        errStep
);

  seqCtl_t           ctl;
  logic              levelMatch, budgetGone, lastStep;
  logic [ADDR_W-1:0] stepAddr;

  peri_reset_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .levelMatch(levelMatch), .budgetGone(budgetGone), .lastStep(lastStep),
    .ctl(ctl), .wrStrobe(wrStrobe), .busy(busy)
  );

  peri_reset_seq_dp #(
    .ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT),
    .CLK_ON_OFS(CLK_ON_OFS), .RST_ON_OFS(RST_ON_OFS), .PAIR_GAP(PAIR_GAP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .clkStatusBit(clkStatusBit), .rstStatusBit(rstStatusBit),
    .levelMatch(levelMatch), .budgetGone(budgetGone), .lastStep(lastStep),
    .stepAddr(stepAddr), .seqDone(seqDone), .seqErr(seqErr), .errStep(errStep)
  );

  assign wrAddr = wrStrobe ? stepAddr : '0;
  assign wrData = wrStrobe ? DATA_W'(1) : '0;

endmodule

// File: rtl/peri_reset_seq_chk.sv
module peri_reset_seq_chk #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int unsigned RST_ON_OFS = 'hA38
)(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wrStrobe,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              seqDone,
  input logic              seqErr
);

  a_r1_first_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (wrStrobe && wrAddr == ADDR_W'(RST_ON_OFS)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  a_r3_data_one: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrData == DATA_W'(1)));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && seqErr));

  a_r6_flags_clear_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!seqDone && !seqErr));

  a_r9_quiet_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !wrStrobe);

endmodule

bind peri_reset_seq peri_reset_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_ON_OFS(RST_ON_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .wrStrobe(wrStrobe),
  .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
  .seqDone(seqDone), .seqErr(seqErr)
);

// File: tb/peri_reset_seq_tb_top.sv
module peri_reset_seq_tb_top;

  localparam int LIMIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        clkBit = 1'b1;
  logic        rstBit = 1'b0;
  logic        wrStrobe, busy, seqDone, seqErr;
  logic [15:0] wrAddr;
  logic [31:0] wrData;
  logic [1:0]  errStep;

  peri_reset_seq #(.POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .clkStatusBit(clkBit), .rstStatusBit(rstBit),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .seqDone(seqDone), .seqErr(seqErr), .errStep(errStep)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: behaviour only, stepped at each rising edge
  int mPhase = 0;   // 0 idle, 1 strobe cycle, 2 waiting on status
  int mStep = 0;
  int mPolls = 0;
  bit mDone = 0, mErr = 0;
  int mErrStep = 0;

  function automatic int addrOf(input int s);
    case (s)
      0: return 'hA38;
      1: return 'h33C;
      2: return 'hA3C;
      default: return 'h338;
    endcase
  endfunction

  function automatic bit confirmed(input int s, input bit r, input bit c);
    case (s)
      0: return r == 1'b1;
      1: return c == 1'b0;
      2: return r == 1'b0;
      default: return c == 1'b1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mStep = 0; mPolls = 0; mDone = 0; mErr = 0; mErrStep = 0;
    end else begin
      case (mPhase)
        0: if (start) begin
             mPhase = 1; mStep = 0; mDone = 0; mErr = 0; mErrStep = 0;
           end
        1: begin mPhase = 2; mPolls = 0; end
        default: begin
          mPolls++;
          if (confirmed(mStep, rstBit, clkBit)) begin
            if (mStep == 3) begin mDone = 1; mPhase = 0; end
            else begin mStep++; mPhase = 1; end
          end else if (mPolls >= LIMIT) begin
            mErr = 1; mErrStep = mStep; mPhase = 0;
          end
        end
      endcase
    end
  end

  // status responder: latency per step, counted in cycles after the strobe
  int lat[4];
  int pendDelay = -1;
  bit pendIsRst = 0;
  bit pendVal = 0;
  int strobeCount = 0;
  int firstAddr = 0;

  always @(negedge clk) begin
    cycles++;
    // per-cycle comparison against the model
    check(wrStrobe == (mPhase == 1), "R3", "wrStrobe", wrStrobe, mPhase == 1);
    if (mPhase == 1) begin
      check(wrAddr == addrOf(mStep), "R2", "wrAddr", wrAddr, addrOf(mStep));
      check(wrData == 1, "R3", "wrData", wrData, 1);
    end
    check(busy == (mPhase != 0), "R7", "busy", busy, mPhase != 0);
    check(seqDone == mDone, "R6", "seqDone", seqDone, mDone);
    check(seqErr == mErr, "R5", "seqErr", seqErr, mErr);
    check(errStep == mErrStep, "R5", "errStep", errStep, mErrStep);
    // respond to strobes
    if (wrStrobe) begin
      if (strobeCount == 0) firstAddr = wrAddr;
      strobeCount++;
      case (wrAddr)
        16'hA38: begin pendIsRst = 1; pendVal = 1; pendDelay = lat[0]; end
        16'h33C: begin pendIsRst = 0; pendVal = 0; pendDelay = lat[1]; end
        16'hA3C: begin pendIsRst = 1; pendVal = 0; pendDelay = lat[2]; end
        default: begin pendIsRst = 0; pendVal = 1; pendDelay = lat[3]; end
      endcase
    end
    if (pendDelay == 0) begin
      if (pendIsRst) rstBit = pendVal; else clkBit = pendVal;
      pendDelay = -1;
    end else if (pendDelay > 0) begin
      pendDelay--;
    end
  end

  task automatic waitIdle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic runSeq(input int l0, input int l1, input int l2, input int l3);
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
    pendDelay = -1; rstBit = 0; clkBit = 1; strobeCount = 0; firstAddr = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    waitIdle();
    @(negedge clk);
  endtask

  initial begin
    lat[0] = 0; lat[1] = 0; lat[2] = 0; lat[3] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!busy && !wrStrobe, "R8", "idle after reset", {busy, wrStrobe}, 0);
    check(!seqDone && !seqErr && errStep == 0, "R8", "flags after reset",
          {seqDone, seqErr, errStep}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R6: immediate responses
    runSeq(0, 0, 0, 0);
    check(firstAddr == 'hA38, "R1", "first strobe addr", firstAddr, 'hA38);
    check(seqDone && !seqErr, "R6", "done after fast run", {seqDone, seqErr}, 2'b10);
    check(strobeCount == 4, "R2", "strobe count", strobeCount, 4);

    // R4: mixed latencies
    runSeq(3, 2, 1, 3);
    check(seqDone && !seqErr, "R4", "done with latencies", {seqDone, seqErr}, 2'b10);

    // R5 boundary: match on last allowed poll
    runSeq(LIMIT, LIMIT, LIMIT, LIMIT);
    check(seqDone && !seqErr, "R5", "match on last poll", {seqDone, seqErr}, 2'b10);

    // R5: one poll too late in step 2
    runSeq(0, 0, LIMIT + 1, 0);
    check(seqErr && !seqDone, "R5", "timeout step 2", {seqDone, seqErr}, 2'b01);
    check(errStep == 2, "R5", "errStep step 2", errStep, 2);
    check(strobeCount == 3, "R2", "no strobe past failed step", strobeCount, 3);

    // R9: quiet after error
    repeat (20) @(negedge clk);
    check(strobeCount == 3 && !busy, "R9", "no strobe while idle", strobeCount, 3);

    // R4: clock never gates -> step 1 fails
    runSeq(0, 1000, 0, 0);
    check(seqErr && errStep == 1, "R4", "clock stays on", {seqErr, errStep}, 3'b101);

    // R5: step 0 and step 3 timeouts
    runSeq(1000, 0, 0, 0);
    check(seqErr && errStep == 0, "R5", "timeout step 0", {seqErr, errStep}, 3'b100);
    runSeq(0, 0, 0, 1000);
    check(seqErr && errStep == 3, "R5", "timeout step 3", {seqErr, errStep}, 3'b111);

    // R6: new start clears error flags
    runSeq(1, 1, 1, 1);
    check(seqDone && !seqErr && errStep == 0, "R6", "start clears error",
          {seqDone, seqErr, errStep}, 4'b1000);

    // R7: start pulses while busy are ignored
    lat[0] = 5; lat[1] = 5; lat[2] = 5; lat[3] = 5;
    pendDelay = -1; rstBit = 0; clkBit = 1; strobeCount = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 4; k++) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    waitIdle();
    @(negedge clk);
    check(strobeCount == 4, "R7", "strobes with extra starts", strobeCount, 4);
    check(seqDone && !seqErr, "R7", "done with extra starts", {seqDone, seqErr}, 2'b10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL R6 watchdog: cycles=%0d expected<%0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule